// File: doc/BRIEF.md
# Decoded Micro-op Cache with Window Fill Rules

This block keeps already-decoded micro-ops so that a front end can replay them instead of decoding the same bytes again. Storage is set-associative. Each entry ("way") holds up to six micro-ops that all start inside the same 32-byte aligned code window. Bits [9:5] of a window address select one of 32 sets, and each set has 8 ways. A decoder feeds one window at a time through the fill port. The fill state machine packs the micro-ops into at most three ways in a staging buffer, applying the branch and jump rules as it goes. If the window fits, the ways are installed one per cycle. If it does not fit, the window is dropped and remembered as uncacheable.

The fill machine has five states. `F_IDLE` moves to `F_PACK` on a fill start, or to `F_SKIP` when the window is already known to be uncacheable. `F_PACK` moves to `F_CLEAR` at the end of the fill. It moves to `F_SKIP` when a fourth way would be needed, or straight to `F_IDLE` when that overflow arrives together with the end of the fill. `F_SKIP` returns to `F_IDLE` at the end of the fill. `F_CLEAR` invalidates any older copy of the window. It then moves to `F_WRITE`, or to `F_IDLE` if nothing was packed. `F_WRITE` writes one way per cycle and returns to `F_IDLE` after the last one. A flush sends the fill machine to `F_IDLE` from any state.

The lookup machine has three states. `L_IDLE` accepts a request and moves to `L_STREAM` on a hit or to `L_MISS` on a miss. `L_MISS` returns to `L_IDLE` after one cycle. `L_STREAM` sends one way per cycle and returns to `L_IDLE` after the last way. The block also counts every change of delivery source between this cache and the legacy decode path.

Top module: `uop_cache`

## Requirements
- R1: Micro-ops of a window are packed in arrival order, at most six per way. A seventh micro-op opens the next way.
- R2: A way holds at most two conditional branches (`uop_cond`=1). A third conditional branch opens a new way.
- R3: An unconditional jump (`uop_jump`=1) is the last micro-op of its way. The next micro-op opens a new way.
- R4: A window may use up to three ways. A window that would need a fourth way is discarded, and no part of it can be found by a lookup.
- R5: A lookup with `lk_target`=0 reports a miss, even when the window is stored.
- R6: For each lookup, `lk_done` pulses one cycle after the request is accepted. On a hit, `lk_hit`=1 and the ways are streamed one per cycle in program order, starting in that same cycle. `rd_last` marks the final way.
- R7: After a window has been discarded, later fills of it install nothing until `flush`. `flush` empties the cache and the record of discarded windows.
- R8: An install takes the lowest invalid way of the set. If no way is invalid, a tree pseudo-LRU picks the victim, where both installs and hits count as use. Evicting a way invalidates every way of the victim's window.
- R9: `switch_count` increases by one whenever the hit/miss outcome of a lookup differs from that of the previous lookup. Before the first lookup, the previous outcome is taken as a miss.
- R10: A micro-op belongs to the window that holds its start byte address (`uop_addr`), even when its instruction runs into the next window. A micro-op whose start address lies outside the window being filled is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the cache and the discarded-window record |
| fill_start | input | 1 | Begin filling the window that contains `fill_win` |
| fill_win | input | AW | Any byte address in the window to fill |
| uop_valid | input | 1 | A micro-op is present on the fill port |
| uop_addr | input | AW | Start byte address of the micro-op's instruction |
| uop_data | input | UW | Micro-op payload |
| uop_cond | input | 1 | Micro-op is a conditional branch |
| uop_jump | input | 1 | Micro-op is an unconditional jump |
| fill_end | input | 1 | Last beat of the fill stream |
| fill_busy | output | 1 | Fill machine is clearing or writing ways |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | AW | Window address to look up |
| lk_target | input | 1 | Request starts at a branch target |
| lk_ready | output | 1 | A lookup request is accepted this cycle |
| lk_done | output | 1 | Lookup outcome is valid |
| lk_hit | output | 1 | Lookup outcome is a hit (valid with `lk_done`) |
| rd_valid | output | 1 | A way is presented on `rd_uops` |
| rd_last | output | 1 | The presented way is the window's last |
| rd_cnt | output | CW | Number of micro-ops in the presented way |
| rd_uops | output | UPW*UW | Micro-ops of the presented way, slot 0 in the low bits |
| switch_count | output | 32 | Count of delivery-source changes |

## Verification
The packing rules are tried with four kinds of streams: plain runs that overflow a way by count, streams of conditional branches that overflow by branch limit, jumps placed in the middle of a stream, and jump-only streams of exactly three and exactly four ways. Comparing way counts and the micro-op in slot 0 of each way shows which rule opened each new way. Fills that straddle a window boundary show whether ownership is decided by start address. A set filled to capacity and then pushed one window further shows whether the pseudo-LRU victim is chosen correctly and whether a multi-way window is evicted whole. Untargeted lookups, repeated fills of a discarded window, and a flush check that gating, the discarded-window record and the switch count behave independently of stored content.

// File: rtl/uop_cache_pkg.sv
package uop_cache_pkg;

    typedef enum logic [2:0] {
        F_IDLE,
        F_PACK,
        F_SKIP,
        F_CLEAR,
        F_WRITE
    } fill_state_t;

    typedef enum logic [1:0] {
        L_IDLE,
        L_MISS,
        L_STREAM
    } look_state_t;

endpackage

// File: rtl/uop_cache_plru.sv
module uop_cache_plru #(
    parameter int WAYS = 8,
    localparam int WYW = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] tree_i,
    input  logic [WYW-1:0]  touch_way,
    output logic [WYW-1:0]  victim_o,
    output logic [WAYS-2:0] tree_o
);

    // Heap-ordered tree: node n has children 2n and 2n+1, bit n-1 = 1 points right.
    always_comb begin
        int n;
        n = 1;
        for (int l = 0; l < WYW; l++) begin
            n = tree_i[n-1] ? (2 * n + 1) : (2 * n);
        end
        victim_o = WYW'(n - WAYS);
    end

    always_comb begin
        int m;
        tree_o = tree_i;
        m = int'(touch_way) + WAYS;
        for (int l = 0; l < WYW; l++) begin
            tree_o[(m / 2) - 1] = ((m % 2) == 0);
            m = m / 2;
        end
    end

endmodule

// File: rtl/uop_cache_reject_table.sv
module uop_cache_reject_table #(
    parameter int TAGW    = 27,
    parameter int ENTRIES = 4,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            set_en,
    input  logic [TAGW-1:0] set_tag,
    input  logic [TAGW-1:0] q_tag,
    output logic            q_hit
);

    logic [TAGW-1:0] tag_q [ENTRIES];
    logic [ENTRIES-1:0] val_q;
    logic [ENTRIES-1:0] match;
    logic [PW-1:0] ptr_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = val_q[e] && (tag_q[e] == q_tag);
    end

    assign q_hit = |match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            ptr_q <= '0;
        end else if (flush) begin
            val_q <= '0;
            ptr_q <= '0;
        end else if (set_en) begin
            val_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[ptr_q] <= set_tag;
    end

endmodule

// File: rtl/uop_cache_fill_packer.sv
module uop_cache_fill_packer
    import uop_cache_pkg::*;
#(
    parameter int AW       = 32,
    parameter int UW       = 16,
    parameter int UPW      = 6,
    parameter int WIN_WAYS = 3,
    parameter int BR_MAX   = 2,
    parameter int OFS      = 5,
    localparam int TAGW    = AW - OFS,
    localparam int WW      = $clog2(WIN_WAYS + 1),
    localparam int CW      = $clog2(UPW + 1),
    localparam int BW      = $clog2(BR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              hold,
    input  logic              fill_start,
    input  logic [AW-1:0]     fill_win,
    input  logic              uop_valid,
    input  logic [AW-1:0]     uop_addr,
    input  logic [UW-1:0]     uop_data,
    input  logic              uop_cond,
    input  logic              uop_jump,
    input  logic              fill_end,
    input  logic              rej_hit,
    output logic              rej_set,
    output logic [TAGW-1:0]   win_tag,
    output logic              busy,
    output logic              clr_req,
    output logic              wr_valid,
    output logic [WW-1:0]     wr_seq,
    output logic [CW-1:0]     wr_cnt,
    output logic [UPW*UW-1:0] wr_uops
);

    fill_state_t st_q, st_nx;
    logic [TAGW-1:0] tag_q;
    logic [WW-1:0]   way_q, wseq_q, tgt, nways;
    logic [CW-1:0]   cnt_q, pos, cnt_nx;
    logic [BW-1:0]   brc_q;
    logic            closed_q, in_win, need_new, over;
    logic [UW-1:0]   stage_q [WIN_WAYS][UPW];
    logic [CW-1:0]   scnt_q  [WIN_WAYS];

    assign in_win   = (st_q == F_PACK) && uop_valid && (uop_addr[AW-1:OFS] == tag_q);
    assign need_new = (cnt_q == CW'(UPW)) || closed_q || (uop_cond && (brc_q == BW'(BR_MAX)));
    assign tgt      = need_new ? way_q + 1'b1 : way_q;
    assign over     = in_win && (tgt == WW'(WIN_WAYS));
    assign pos      = need_new ? '0 : cnt_q;
    assign cnt_nx   = pos + 1'b1;
    assign nways    = (cnt_q == '0) ? '0 : way_q + 1'b1;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            F_IDLE:  if (fill_start) st_nx = rej_hit ? F_SKIP : F_PACK;
            F_PACK:  if (over) st_nx = fill_end ? F_IDLE : F_SKIP;
                     else if (fill_end) st_nx = F_CLEAR;
            F_SKIP:  if (fill_end) st_nx = F_IDLE;
            F_CLEAR: if (!hold) st_nx = (nways == '0) ? F_IDLE : F_WRITE;
            F_WRITE: if (!hold && (wseq_q == nways - 1'b1)) st_nx = F_IDLE;
            default: st_nx = F_IDLE;
        endcase
        if (flush) st_nx = F_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= F_IDLE;
            tag_q    <= '0;
            way_q    <= '0;
            cnt_q    <= '0;
            brc_q    <= '0;
            closed_q <= 1'b0;
            wseq_q   <= '0;
        end else begin
            st_q <= st_nx;
            if (st_q == F_IDLE && fill_start) begin
                tag_q    <= fill_win[AW-1:OFS];
                way_q    <= '0;
                cnt_q    <= '0;
                brc_q    <= '0;
                closed_q <= 1'b0;
                wseq_q   <= '0;
            end else if (in_win && !over) begin
                way_q    <= tgt;
                cnt_q    <= cnt_nx;
                brc_q    <= (need_new ? '0 : brc_q) + BW'(uop_cond);
                closed_q <= uop_jump;
            end else if (st_q == F_WRITE && !hold) begin
                wseq_q <= wseq_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_win && !over) begin
            stage_q[tgt][pos] <= uop_data;
            scnt_q[tgt]       <= cnt_nx;
        end
    end

    always_comb begin
        rej_set  = over;
        win_tag  = tag_q;
        busy     = (st_q == F_CLEAR) || (st_q == F_WRITE);
        clr_req  = (st_q == F_CLEAR) && !hold;
        wr_valid = (st_q == F_WRITE) && !hold;
        wr_seq   = wseq_q;
        wr_cnt   = scnt_q[wseq_q];
    end

    for (genvar i = 0; i < UPW; i++) begin : g_out
        assign wr_uops[i*UW +: UW] = stage_q[wseq_q][i];
    end

    p_branch_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        brc_q <= BW'(BR_MAX));
    p_way_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_cnt != '0) && (wr_cnt <= CW'(UPW)));
    p_win_ways_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_seq < WW'(WIN_WAYS));
    p_jump_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !over && uop_jump && !fill_end) |=> (!in_win || need_new));

endmodule

// File: rtl/uop_cache.sv
module uop_cache
    import uop_cache_pkg::*;
#(
    parameter int AW        = 32,
    parameter int UW        = 16,
    parameter int SETS      = 32,
    parameter int WAYS      = 8,
    parameter int UPW       = 6,
    parameter int WIN_BYTES = 32,
    parameter int WIN_WAYS  = 3,
    parameter int BR_MAX    = 2,
    parameter int REJ_N     = 4,
    localparam int OFS      = $clog2(WIN_BYTES),
    localparam int SETW     = $clog2(SETS),
    localparam int TAGW     = AW - OFS,
    localparam int WYW      = $clog2(WAYS),
    localparam int WW       = $clog2(WIN_WAYS + 1),
    localparam int CW       = $clog2(UPW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_start,
    input  logic [AW-1:0]     fill_win,
    input  logic              uop_valid,
    input  logic [AW-1:0]     uop_addr,
    input  logic [UW-1:0]     uop_data,
    input  logic              uop_cond,
    input  logic              uop_jump,
    input  logic              fill_end,
    output logic              fill_busy,
    input  logic              lk_req,
    input  logic [AW-1:0]     lk_addr,
    input  logic              lk_target,
    output logic              lk_ready,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [CW-1:0]     rd_cnt,
    output logic [UPW*UW-1:0] rd_uops,
    output logic [31:0]       switch_count
);

    logic              v_q    [SETS][WAYS];
    logic [TAGW-1:0]   tag_q  [SETS][WAYS];
    logic [WW-1:0]     seq_q  [SETS][WAYS];
    logic [CW-1:0]     cnt_q  [SETS][WAYS];
    logic [UPW*UW-1:0] dat_q  [SETS][WAYS];
    logic [WAYS-2:0]   plru_q [SETS];

    logic rej_hit, rej_set, clr_req, wr_valid, hold;
    logic [TAGW-1:0] win_tag;
    logic [WW-1:0] wr_seq;
    logic [CW-1:0] wr_cnt;
    logic [UPW*UW-1:0] wr_uops;

    uop_cache_reject_table #(.TAGW(TAGW), .ENTRIES(REJ_N)) u_rej (
        .clk(clk), .rst_n(rst_n), .flush(flush), .set_en(rej_set),
        .set_tag(win_tag), .q_tag(fill_win[AW-1:OFS]), .q_hit(rej_hit)
    );

    uop_cache_fill_packer #(.AW(AW), .UW(UW), .UPW(UPW), .WIN_WAYS(WIN_WAYS),
                            .BR_MAX(BR_MAX), .OFS(OFS)) u_pack (
        .clk(clk), .rst_n(rst_n), .flush(flush), .hold(hold),
        .fill_start(fill_start), .fill_win(fill_win), .uop_valid(uop_valid),
        .uop_addr(uop_addr), .uop_data(uop_data), .uop_cond(uop_cond),
        .uop_jump(uop_jump), .fill_end(fill_end), .rej_hit(rej_hit),
        .rej_set(rej_set), .win_tag(win_tag), .busy(fill_busy),
        .clr_req(clr_req), .wr_valid(wr_valid), .wr_seq(wr_seq),
        .wr_cnt(wr_cnt), .wr_uops(wr_uops)
    );

    // ---- install side ----
    logic [SETW-1:0] wset;
    logic [WYW-1:0]  inv_way, victim, plru_victim, head_way, touch_way;
    logic            have_inv, evict;
    logic [TAGW-1:0] victim_tag;
    logic [WAYS-2:0] tree_in, tree_nx;

    assign wset = win_tag[SETW-1:0];

    always_comb begin
        have_inv = 1'b0;
        inv_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!v_q[wset][w]) begin
                have_inv = 1'b1;
                inv_way  = WYW'(w);
            end
        end
    end

    assign victim     = have_inv ? inv_way : plru_victim;
    assign evict      = v_q[wset][victim];
    assign victim_tag = tag_q[wset][victim];

    // ---- lookup side ----
    look_state_t lst_q, lst_nx;
    logic [SETW-1:0] lset, lset_q;
    logic [TAGW-1:0] ltag;
    logic [WAYS-1:0] lmask_now, lmask_q;
    logic [WW-1:0]   lnum_now, lnum_q, rseq_q;
    logic            head_found, lk_accept, hit_now, last_src_q;
    logic [WYW-1:0]  sel_way;

    assign lset      = lk_addr[OFS +: SETW];
    assign ltag      = lk_addr[AW-1:OFS];
    assign lk_ready  = (lst_q == L_IDLE) && !fill_busy;
    assign lk_accept = lk_req && lk_ready;
    assign hit_now   = lk_target && head_found;
    assign hold      = (lst_q != L_IDLE);

    always_comb begin
        head_found = 1'b0;
        head_way   = '0;
        lmask_now  = '0;
        lnum_now   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (v_q[lset][w] && (tag_q[lset][w] == ltag)) begin
                lmask_now[w] = 1'b1;
                lnum_now     = lnum_now + 1'b1;
                if (seq_q[lset][w] == '0) begin
                    head_found = 1'b1;
                    head_way   = WYW'(w);
                end
            end
        end
    end

    assign tree_in   = wr_valid ? plru_q[wset] : plru_q[lset];
    assign touch_way = wr_valid ? victim : head_way;

    uop_cache_plru #(.WAYS(WAYS)) u_plru (
        .tree_i(tree_in), .touch_way(touch_way),
        .victim_o(plru_victim), .tree_o(tree_nx)
    );

    always_comb begin
        lst_nx = lst_q;
        unique case (lst_q)
            L_IDLE:   if (lk_accept) lst_nx = hit_now ? L_STREAM : L_MISS;
            L_MISS:   lst_nx = L_IDLE;
            L_STREAM: if (rseq_q == lnum_q - 1'b1) lst_nx = L_IDLE;
            default:  lst_nx = L_IDLE;
        endcase
    end

    always_comb begin
        sel_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lmask_q[w] && (seq_q[lset_q][w] == rseq_q)) sel_way = WYW'(w);
        end
    end

    always_comb begin
        lk_done  = (lst_q == L_MISS) || ((lst_q == L_STREAM) && (rseq_q == '0));
        lk_hit   = (lst_q == L_STREAM) && (rseq_q == '0);
        rd_valid = (lst_q == L_STREAM);
        rd_last  = (lst_q == L_STREAM) && (rseq_q == lnum_q - 1'b1);
        rd_cnt   = cnt_q[lset_q][sel_way];
        rd_uops  = dat_q[lset_q][sel_way];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lst_q        <= L_IDLE;
            lset_q       <= '0;
            lmask_q      <= '0;
            lnum_q       <= '0;
            rseq_q       <= '0;
            last_src_q   <= 1'b0;
            switch_count <= '0;
        end else begin
            lst_q <= lst_nx;
            if (lk_accept) begin
                lset_q  <= lset;
                lmask_q <= lmask_now;
                lnum_q  <= lnum_now;
                rseq_q  <= '0;
            end else if (lst_q == L_STREAM) begin
                rseq_q <= rseq_q + 1'b1;
            end
            if (lk_done) begin
                last_src_q <= lk_hit;
                if (lk_hit != last_src_q) switch_count <= switch_count + 32'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                plru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                plru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
            end
        end else begin
            if (clr_req) begin
                for (int w = 0; w < WAYS; w++)
                    if (tag_q[wset][w] == win_tag) v_q[wset][w] <= 1'b0;
            end
            if (wr_valid) begin
                for (int w = 0; w < WAYS; w++)
                    if (evict && (tag_q[wset][w] == victim_tag)) v_q[wset][w] <= 1'b0;
                v_q[wset][victim] <= 1'b1;
                plru_q[wset]      <= tree_nx;
            end else if (lk_accept && hit_now) begin
                plru_q[lset] <= tree_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_valid) begin
            tag_q[wset][victim] <= win_tag;
            seq_q[wset][victim] <= wr_seq;
            cnt_q[wset][victim] <= wr_cnt;
            dat_q[wset][victim] <= wr_uops;
        end
    end

    p_untargeted_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_accept && !lk_target) |=> (lk_done && !lk_hit));
    p_stream_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> (rd_valid && !lk_done));
    p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_accept |=> lk_done);
    p_switch_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((switch_count == $past(switch_count)) ||
                  (switch_count == $past(switch_count) + 32'd1)));
    p_way_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_cnt != '0));

endmodule

// File: tb/uop_cache_tb.sv
module uop_cache_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic fill_start = 1'b0;
    logic [31:0] fill_win = '0;
    logic uop_valid = 1'b0;
    logic [31:0] uop_addr = '0;
    logic [15:0] uop_data = '0;
    logic uop_cond = 1'b0;
    logic uop_jump = 1'b0;
    logic fill_end = 1'b0;
    logic fill_busy;
    logic lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic lk_target = 1'b0;
    logic lk_ready, lk_done, lk_hit, rd_valid, rd_last;
    logic [2:0] rd_cnt;
    logic [95:0] rd_uops;
    logic [31:0] switch_count;

    always #2 clk = ~clk;

    uop_cache u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_start(fill_start),
        .fill_win(fill_win), .uop_valid(uop_valid), .uop_addr(uop_addr),
        .uop_data(uop_data), .uop_cond(uop_cond), .uop_jump(uop_jump),
        .fill_end(fill_end), .fill_busy(fill_busy), .lk_req(lk_req),
        .lk_addr(lk_addr), .lk_target(lk_target), .lk_ready(lk_ready),
        .lk_done(lk_done), .lk_hit(lk_hit), .rd_valid(rd_valid),
        .rd_last(rd_last), .rd_cnt(rd_cnt), .rd_uops(rd_uops),
        .switch_count(switch_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int exp_sw = 0;
    bit last_src = 1'b0;

    logic [31:0] q_addr [16];
    logic [15:0] q_data [16];
    logic        q_cond [16];
    logic        q_jump [16];
    int          q_n = 0;

    bit          got_hit;
    int          got_n;
    int          got_cnt [4];
    logic [15:0] got_u [4][6];

    task automatic eq(input string rq, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [15:0] d, input bit c, input bit j);
        q_addr[q_n] = a; q_data[q_n] = d; q_cond[q_n] = c; q_jump[q_n] = j;
        q_n++;
    endtask

    task automatic run_fill(input logic [31:0] win);
        while (fill_busy) @(negedge clk);
        fill_start = 1'b1; fill_win = win;
        @(negedge clk);
        fill_start = 1'b0;
        for (int i = 0; i < q_n; i++) begin
            uop_valid = 1'b1; uop_addr = q_addr[i]; uop_data = q_data[i];
            uop_cond = q_cond[i]; uop_jump = q_jump[i];
            @(negedge clk);
        end
        uop_valid = 1'b0; uop_cond = 1'b0; uop_jump = 1'b0;
        fill_end = 1'b1;
        @(negedge clk);
        fill_end = 1'b0;
        @(negedge clk);
        while (fill_busy) @(negedge clk);
        q_n = 0;
    endtask

    task automatic lookup(input logic [31:0] a, input bit tgt);
        while (!lk_ready) @(negedge clk);
        lk_req = 1'b1; lk_addr = a; lk_target = tgt;
        @(negedge clk);
        lk_req = 1'b0;
        eq("R6 done one cycle after accept", lk_done, 1);
        got_hit = lk_hit;
        got_n = 0;
        while (rd_valid) begin
            if (got_n < 4) begin
                got_cnt[got_n] = rd_cnt;
                for (int i = 0; i < 6; i++) got_u[got_n][i] = rd_uops[i*16 +: 16];
            end
            got_n++;
            if (rd_last) break;
            @(negedge clk);
        end
        @(negedge clk);
        if (got_hit != last_src) exp_sw++;
        last_src = got_hit;
    endtask

    task automatic t_reset;
        eq("R6 reset lk_ready", lk_ready, 1);
        eq("R6 reset rd_valid", rd_valid, 0);
        eq("R9 reset switch_count", switch_count, 0);
        eq("R1 reset fill_busy", fill_busy, 0);
    endtask

    task automatic t_pack_r1;
        for (int i = 0; i < 8; i++) push(32'h100 + 3 * i, 16'h1000 + 16'(i), 0, 0);
        run_fill(32'h100);
        lookup(32'h104, 1);
        eq("R1 hit", got_hit, 1);
        eq("R1 ways", got_n, 2);
        eq("R1 way0 count", got_cnt[0], 6);
        eq("R1 way1 count", got_cnt[1], 2);
        eq("R6 order way0 slot5", got_u[0][5], 16'h1005);
        eq("R6 order way1 slot0", got_u[1][0], 16'h1006);
    endtask

    task automatic t_cond_r2;
        push(32'h200, 16'h2000, 1, 0);
        push(32'h202, 16'h2001, 1, 0);
        push(32'h204, 16'h2002, 1, 0);
        push(32'h206, 16'h2003, 0, 0);
        run_fill(32'h200);
        lookup(32'h200, 1);
        eq("R2 ways", got_n, 2);
        eq("R2 way0 count", got_cnt[0], 2);
        eq("R2 way1 count", got_cnt[1], 2);
        eq("R2 way1 head", got_u[1][0], 16'h2002);
    endtask

    task automatic t_jump_r3;
        push(32'h300, 16'h3000, 0, 0);
        push(32'h302, 16'h3001, 0, 1);
        push(32'h304, 16'h3002, 0, 0);
        run_fill(32'h300);
        lookup(32'h300, 1);
        eq("R3 ways", got_n, 2);
        eq("R3 way0 count", got_cnt[0], 2);
        eq("R3 way1 count", got_cnt[1], 1);
        eq("R3 way1 head", got_u[1][0], 16'h3002);
    endtask

    task automatic t_untarget_r5;
        lookup(32'h100, 0);
        eq("R5 untargeted miss", got_hit, 0);
        eq("R5 no stream", got_n, 0);
        lookup(32'h100, 1);
        eq("R5 targeted still hits", got_hit, 1);
    endtask

    task automatic t_limit_r4;
        for (int i = 0; i < 3; i++) push(32'h440 + 2 * i, 16'h4400 + 16'(i), 0, 1);
        run_fill(32'h440);
        lookup(32'h440, 1);
        eq("R4 three ways fit", got_n, 3);
        eq("R4 third way head", got_u[2][0], 16'h4402);
        for (int i = 0; i < 4; i++) push(32'h400 + 2 * i, 16'h4000 + 16'(i), 0, 1);
        run_fill(32'h400);
        lookup(32'h400, 1);
        eq("R4 four ways rejected", got_hit, 0);
    endtask

    task automatic t_sticky_r7;
        push(32'h400, 16'h4100, 0, 0);
        run_fill(32'h400);
        lookup(32'h400, 1);
        eq("R7 refill of rejected window ignored", got_hit, 0);
    endtask

    task automatic t_span_r10;
        push(32'h51E, 16'h5000, 0, 0);
        push(32'h520, 16'h5001, 0, 0);
        push(32'h510, 16'h5002, 0, 0);
        run_fill(32'h500);
        lookup(32'h500, 1);
        eq("R10 ways", got_n, 1);
        eq("R10 count", got_cnt[0], 2);
        eq("R10 straddling uop kept", got_u[0][0], 16'h5000);
        eq("R10 outside uop dropped", got_u[0][1], 16'h5002);
    endtask

    task automatic t_evict_r8;
        for (int i = 0; i < 7; i++) push(32'h060 + i, 16'hA000 + 16'(i), 0, 0);
        run_fill(32'h060);
        for (int k = 1; k < 8; k++) begin
            push(32'h060 + 32'(k) * 32'h400, 16'hB000 + 16'(k), 0, 0);
            run_fill(32'h060 + 32'(k) * 32'h400);
        end
        lookup(32'h060, 1);
        eq("R8 pLRU victim window evicted whole", got_hit, 0);
        for (int k = 1; k < 7; k++) begin
            lookup(32'h060 + 32'(k) * 32'h400, 1);
            eq("R8 other windows kept", got_hit, 1);
        end
        lookup(32'h1C60, 1);
        eq("R8 new window installed", got_hit, 1);
        eq("R8 new window data", got_u[0][0], 16'hB007);
    endtask

    task automatic t_flush_r7;
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup(32'h100, 1);
        eq("R7 flush empties cache", got_hit, 0);
        push(32'h400, 16'h4200, 0, 0);
        run_fill(32'h400);
        lookup(32'h400, 1);
        eq("R7 flush clears reject record", got_hit, 1);
        eq("R7 refilled data", got_u[0][0], 16'h4200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_pack_r1;
        t_cond_r2;
        t_jump_r3;
        t_untarget_r5;
        t_limit_r4;
        t_sticky_r7;
        t_span_r10;
        t_evict_r8;
        t_flush_r7;
        eq("R9 switch count", switch_count, exp_sw);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule